// File: doc/BRIEF.md
# Serial Audio Transmit Shifter

This block turns parallel audio samples into a framed serial stream. A frame is made of `CHANNELS` slots of `SLOT_W` bit periods each. Every slot carries one `SAMPLE_W`-bit sample, most significant bit first, followed by padding bits up to the slot length. A word-select line marks which slot is being sent. Timing comes from `bit_tick`, a one-cycle pulse from an external divider that stands for the falling edge of the bit clock. All serial outputs change only on those pulses, so a receiver can sample them on the rising edge.

Samples arrive through a valid/ready handshake into a one-word holding register. The holding register is emptied into the shifter at the start of each slot, which lets words follow one another with no gap. Control inputs do the following:
- select a one-bit or zero-bit lag between a word-select change and the first data bit;
- enable a compressed mode, which forces the zero-bit lag;
- enable a burst mode that gates the bit clock;
- mute the data line;
- choose the level of the padding bits.

Top module: `audio_ser_tx`

## Requirements
- R1: While `rst_n` is low and after its release until the first `bit_tick`, `ser_data`, `word_sel`, `sck_en` and `underflow` are 0 and `s_ready` is 1.
- R2: Each `bit_tick` starts one bit period. Slots are `SLOT_W` periods long. `word_sel` is 0 during even-numbered slots (the first slot after reset is slot 0) and 1 during odd-numbered ones. The serial outputs change only in the cycle after a `bit_tick`. Within a slot the sample goes out MSB first, then padding at the level of `ctl_padhi`.
- R3: With `ctl_nodelay`=0 and `ctl_compress`=0, the MSB of a slot's sample appears one bit period after the `word_sel` change. The period of the change carries the last padding bit of the previous slot.
- R4: With `ctl_nodelay`=1, the MSB appears in the same bit period as the `word_sel` change.
- R5: With `ctl_compress`=1, the zero-bit lag of R4 applies whatever the value of `ctl_nodelay`.
- R6: With `ctl_mute`=1 at a `bit_tick`, `ser_data` is 0 for that bit period, whatever the value of `ctl_padhi`. Framing on `word_sel` continues.
- R7: `s_ready` falls in the cycle after a sample is accepted (`s_valid`=1 and `s_ready`=1). It stays low until a slot start moves the held sample into the shifter, and rises in the cycle after that `bit_tick`.
- R8: Outside effective burst mode, if no sample is held at a slot start, `underflow` is 1 for that bit period. The whole slot carries padding and framing carries on.
- R9: Burst mode takes effect only when `ctl_burst`=1 and `ctl_compress`=1. Otherwise `sck_en` is 1 in every bit period after the first `bit_tick`.
- R10: In effective burst mode, `sck_en` is 1 in the bit periods that carry sample bits and 0 in padding periods.
- R11: In effective burst mode, if no sample is held at a slot start, the frame stalls. `word_sel` keeps its value, `sck_en` and `ser_data` are 0 and `underflow` stays 0. The next `bit_tick` after a sample has been accepted starts the slot with that sample's MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit period (bit-clock falling edge) |
| s_data | input | SAMPLE_W | Sample word offered for transmission |
| s_valid | input | 1 | `s_data` is valid |
| s_ready | output | 1 | Holding register is empty and can take a word |
| ctl_nodelay | input | 1 | 1: zero-bit lag between word select and data; 0: one-bit lag |
| ctl_compress | input | 1 | Compressed mode; forces zero lag and allows burst mode |
| ctl_burst | input | 1 | Request for a gated bit clock |
| ctl_mute | input | 1 | Forces the data line low |
| ctl_padhi | input | 1 | Level of the padding bits |
| ser_data | output | 1 | Serial data |
| word_sel | output | 1 | Slot marker, high in odd-numbered slots |
| sck_en | output | 1 | Bit-clock enable for the current bit period |
| underflow | output | 1 | High for the bit period of a slot start that found no sample |

## Verification
Every cycle, the bound assertions check these rules:
- serial outputs move only after a tick;
- a muted tick yields a low data bit;
- the handshake drops ready after an accept and keeps it low between ticks;
- the bit clock stays enabled when burst mode is not in force;
- underflow is never raised in burst mode.

Some behaviour needs a known sample stream and a bit-exact expected sequence, so only the directed scenarios can show it. This covers the position of each data bit relative to the word-select edge in both lag settings and in compressed mode, MSB-first order, the padding level, the underflow slot filled with padding, and the gated enable pattern. It also covers the frozen frame during a burst stall and its restart.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

   // Control bits after the mode rules have been applied.
   typedef struct packed {
      logic lag_one;    // one bit period between slot marker and MSB
      logic burst;      // gated clock in force
      logic mute;
      logic padhi;
   } tx_mode_t;

   function automatic tx_mode_t resolve_mode(input logic nodelay, input logic compress,
                                             input logic burst, input logic mute,
                                             input logic padhi);
      tx_mode_t m;
      m.lag_one = !(nodelay || compress);
      m.burst   = burst && compress;
      m.mute    = mute;
      m.padhi   = padhi;
      return m;
   endfunction

endpackage

// File: rtl/atx_slot_counter.sv
module atx_slot_counter #(
   parameter int SLOT_W   = 24,
   parameter int CHANNELS = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        advance,
   output logic [$clog2(SLOT_W)-1:0]   nxt_bit,
   output logic                        word_sel
);
   localparam int BIT_CW  = $clog2(SLOT_W);
   localparam int SLOT_CW = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;
   localparam logic [BIT_CW-1:0]  LAST_BIT  = BIT_CW'(SLOT_W - 1);
   localparam logic [SLOT_CW-1:0] LAST_SLOT = SLOT_CW'(CHANNELS - 1);

   logic [BIT_CW-1:0]  bit_q;
   logic [SLOT_CW-1:0] slot_q;
   logic [SLOT_CW-1:0] nxt_slot;

   always_comb begin
      if (bit_q == LAST_BIT) begin
         nxt_bit  = '0;
         nxt_slot = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end else begin
         nxt_bit  = bit_q + 1'b1;
         nxt_slot = slot_q;
      end
   end

   // Reset parks the counter on the last bit of the last slot so that
   // the first advance opens slot 0.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q    <= LAST_BIT;
         slot_q   <= LAST_SLOT;
         word_sel <= 1'b0;
      end else if (advance) begin
         bit_q    <= nxt_bit;
         slot_q   <= nxt_slot;
         word_sel <= nxt_slot[0];
      end
   end

endmodule

// File: rtl/atx_sample_hold.sv
module atx_sample_hold #(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] in_data,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic                take,
   output logic                held,
   output logic [SAMPLE_W-1:0] held_word
);
   logic accept;

   assign in_ready = !held;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held      <= 1'b0;
         held_word <= '0;
      end else begin
         if (take)
            held <= 1'b0;
         if (accept) begin
            held      <= 1'b1;
            held_word <= in_data;
         end
      end
   end

endmodule

// File: rtl/atx_bit_shifter.sv
module atx_bit_shifter
   import audio_tx_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int SLOT_W   = 24
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        advance,
   input  logic                        stall,
   input  logic                        load,
   input  logic                        held,
   input  logic [SAMPLE_W-1:0]         held_word,
   input  logic [$clog2(SLOT_W)-1:0]   pos_nxt,
   input  tx_mode_t                    mode,
   output logic                        ser_data,
   output logic                        sck_en,
   output logic                        underflow
);
   localparam int BIT_CW = $clog2(SLOT_W);

   logic [SAMPLE_W-1:0] sh_q;
   logic                pad_word_q;
   logic                in_sample;
   logic                word_real;
   logic                bit_val;
   logic [SAMPLE_W-1:0] sh_d;

   // Padding exists only when the slot is longer than the sample.
   generate
      if (SLOT_W == SAMPLE_W) begin : g_no_pad
         assign in_sample = 1'b1;
      end else begin : g_pad
         localparam logic [BIT_CW:0] SAMPLE_END = (BIT_CW+1)'(SAMPLE_W);
         assign in_sample = ({1'b0, pos_nxt} < SAMPLE_END);
      end
   endgenerate

   always_comb begin
      if (load) begin
         word_real = held;
         bit_val   = held ? held_word[SAMPLE_W-1] : mode.padhi;
         sh_d      = held ? {held_word[SAMPLE_W-2:0], 1'b0} : '0;
      end else begin
         word_real = !pad_word_q;
         bit_val   = (in_sample && !pad_word_q) ? sh_q[SAMPLE_W-1] : mode.padhi;
         sh_d      = {sh_q[SAMPLE_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q       <= '0;
         pad_word_q <= 1'b1;
         ser_data   <= 1'b0;
         sck_en     <= 1'b0;
         underflow  <= 1'b0;
      end else if (stall) begin
         ser_data   <= 1'b0;
         sck_en     <= 1'b0;
         underflow  <= 1'b0;
      end else if (advance) begin
         sh_q       <= sh_d;
         if (load)
            pad_word_q <= !held;
         ser_data   <= mode.mute ? 1'b0 : bit_val;
         sck_en     <= !mode.burst || (in_sample && word_real);
         underflow  <= load && !held;
      end
   end

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
   import audio_tx_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int SLOT_W   = 24,
   parameter int CHANNELS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_tick,
   input  logic [SAMPLE_W-1:0] s_data,
   input  logic                s_valid,
   output logic                s_ready,
   input  logic                ctl_nodelay,
   input  logic                ctl_compress,
   input  logic                ctl_burst,
   input  logic                ctl_mute,
   input  logic                ctl_padhi,
   output logic                ser_data,
   output logic                word_sel,
   output logic                sck_en,
   output logic                underflow
);
   localparam int BIT_CW = $clog2(SLOT_W);
   localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(SLOT_W - 1);

   generate
      if (SAMPLE_W < 2) begin : g_bad_sample
         $error("SAMPLE_W must be at least 2");
      end
      if (SLOT_W < SAMPLE_W) begin : g_bad_slot
         $error("SLOT_W must not be smaller than SAMPLE_W");
      end
      if (CHANNELS < 2) begin : g_bad_chan
         $error("CHANNELS must be at least 2");
      end
   endgenerate

   tx_mode_t          mode;
   logic [BIT_CW-1:0] nxt_bit;
   logic [BIT_CW-1:0] pos_nxt;
   logic              load;
   logic              stall;
   logic              advance;
   logic              held;
   logic [SAMPLE_W-1:0] held_word;
   logic              take;

   assign mode = resolve_mode(ctl_nodelay, ctl_compress, ctl_burst, ctl_mute, ctl_padhi);

   // Stream position inside the slot word for the coming bit period.
   always_comb begin
      if (mode.lag_one)
         pos_nxt = (nxt_bit == '0) ? LAST_BIT : nxt_bit - 1'b1;
      else
         pos_nxt = nxt_bit;
   end

   assign load    = (pos_nxt == '0);
   assign stall   = bit_tick && mode.burst && load && !held;
   assign advance = bit_tick && !stall;
   assign take    = advance && load && held;

   atx_slot_counter #(
      .SLOT_W   (SLOT_W),
      .CHANNELS (CHANNELS)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (advance),
      .nxt_bit  (nxt_bit),
      .word_sel (word_sel)
   );

   atx_sample_hold #(
      .SAMPLE_W (SAMPLE_W)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_data   (s_data),
      .in_valid  (s_valid),
      .in_ready  (s_ready),
      .take      (take),
      .held      (held),
      .held_word (held_word)
   );

   atx_bit_shifter #(
      .SAMPLE_W (SAMPLE_W),
      .SLOT_W   (SLOT_W)
   ) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (advance),
      .stall     (stall),
      .load      (load),
      .held      (held),
      .held_word (held_word),
      .pos_nxt   (pos_nxt),
      .mode      (mode),
      .ser_data  (ser_data),
      .sck_en    (sck_en),
      .underflow (underflow)
   );

endmodule

// File: rtl/audio_ser_tx_checker.sv
module audio_ser_tx_checker (
   input logic clk,
   input logic rst_n,
   input logic bit_tick,
   input logic s_valid,
   input logic s_ready,
   input logic ctl_compress,
   input logic ctl_burst,
   input logic ctl_mute,
   input logic ser_data,
   input logic word_sel,
   input logic sck_en,
   input logic underflow
);

   assert_tick_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> ($stable(word_sel) && $stable(ser_data) && $stable(sck_en) && $stable(underflow)));

   assert_mute_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && ctl_mute) |=> !ser_data);

   assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready) |=> !s_ready);

   assert_ready_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_ready && !bit_tick) |=> !s_ready);

   assert_clock_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && !(ctl_burst && ctl_compress)) |=> sck_en);

   assert_no_underflow_burst_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && ctl_burst && ctl_compress) |=> !underflow);

endmodule

bind audio_ser_tx audio_ser_tx_checker u_audio_ser_tx_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .bit_tick     (bit_tick),
   .s_valid      (s_valid),
   .s_ready      (s_ready),
   .ctl_compress (ctl_compress),
   .ctl_burst    (ctl_burst),
   .ctl_mute     (ctl_mute),
   .ser_data     (ser_data),
   .word_sel     (word_sel),
   .sck_en       (sck_en),
   .underflow    (underflow)
);

// File: tb/test_audio_ser_tx.sv
module test_audio_ser_tx;
   localparam int SW  = 16;
   localparam int SLW = 24;
   localparam int CH  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_tick = 1'b0;
   logic [SW-1:0] s_data = '0;
   logic          s_valid = 1'b0;
   logic          s_ready;
   logic          ctl_nodelay = 1'b0, ctl_compress = 1'b0, ctl_burst = 1'b0;
   logic          ctl_mute = 1'b0, ctl_padhi = 1'b0;
   logic          ser_data, word_sel, sck_en, underflow;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [SW-1:0] samp [0:7];

   always #10 clk = ~clk;

   audio_ser_tx #(.SAMPLE_W(SW), .SLOT_W(SLW), .CHANNELS(CH)) i_audio_ser_tx (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .s_data(s_data), .s_valid(s_valid),
      .s_ready(s_ready), .ctl_nodelay(ctl_nodelay), .ctl_compress(ctl_compress),
      .ctl_burst(ctl_burst), .ctl_mute(ctl_mute), .ctl_padhi(ctl_padhi),
      .ser_data(ser_data), .word_sel(word_sel), .sck_en(sck_en), .underflow(underflow));

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic apply_reset(input logic nd, input logic cp, input logic bu,
                              input logic mu, input logic ph);
      @(negedge clk);
      rst_n = 1'b0; bit_tick = 1'b0; s_valid = 1'b0;
      ctl_nodelay = nd; ctl_compress = cp; ctl_burst = bu; ctl_mute = mu; ctl_padhi = ph;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // One bit period: pulse for one clock, then outputs are read at a falling edge.
   task automatic tick();
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
   endtask

   task automatic feed(input int first, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         s_valid = 1'b1;
         s_data  = samp[first + i];
         while (!s_ready) @(negedge clk);
         @(negedge clk);
         s_valid = 1'b0;
      end
   endtask

   function automatic logic exp_bit(input int t, input int lag, input logic mu, input logic ph);
      int k, w, p;
      k = t % SLW; w = t / SLW; p = k - lag;
      if (mu) return 1'b0;
      if (p >= 0 && p < SW) return samp[w][SW-1-p];
      return ph;
   endfunction

   task automatic run_stream(input string tag, input logic nd, input logic cp,
                             input logic mu, input logic ph, input int lag);
      apply_reset(nd, cp, 1'b0, mu, ph);
      fork
         feed(0, 4);
         begin
            repeat (2) @(negedge clk);
            for (int t = 0; t < 3 * SLW; t++) begin
               tick();
               chk(tag, ser_data, exp_bit(t, lag, mu, ph));
               chk(tag, word_sel, (((t / SLW) % CH) % 2) == 1);
               chk(tag, sck_en, 1'b1);
               chk(tag, underflow, 1'b0);
            end
         end
      join
   endtask

   task automatic t_reset();
      apply_reset(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      repeat (3) @(negedge clk);
      chk("R1 data", ser_data, 1'b0);
      chk("R1 ws", word_sel, 1'b0);
      chk("R1 sck", sck_en, 1'b0);
      chk("R1 uf", underflow, 1'b0);
      chk("R1 ready", s_ready, 1'b1);
   endtask

   task automatic t_handshake();
      apply_reset(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R7 idle ready", s_ready, 1'b1);
      feed(0, 1);
      chk("R7 ready low after accept", s_ready, 1'b0);
      repeat (4) @(negedge clk);
      chk("R7 ready held low", s_ready, 1'b0);
      tick();
      chk("R7 ready after load", s_ready, 1'b1);
      chk("R7 msb out", ser_data, samp[0][SW-1]);
      feed(1, 1);
      tick();
      chk("R7 ready low mid slot", s_ready, 1'b0);
      chk("R7 second bit", ser_data, samp[0][SW-2]);
   endtask

   task automatic t_underflow();
      apply_reset(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      feed(0, 1);
      for (int t = 0; t < 2 * SLW; t++) begin
         tick();
         chk("R8 uf", underflow, (t == SLW));
         chk("R8 data", ser_data, (t < SW) ? samp[0][SW-1-t] : 1'b1);
         chk("R8 ws", word_sel, t >= SLW);
      end
   endtask

   task automatic t_burst_ignored();
      apply_reset(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      for (int t = 0; t < 2 * SLW; t++) begin
         tick();
         chk("R9 sck", sck_en, 1'b1);
         chk("R9 ws", word_sel, t >= SLW);
         chk("R9 uf", underflow, (t % SLW) == 0);
      end
   endtask

   task automatic t_burst();
      apply_reset(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
      feed(0, 1);
      for (int t = 0; t < SLW; t++) begin
         tick();
         chk("R10 sck gate", sck_en, t < SW);
         if (t < SW) chk("R10 data", ser_data, samp[0][SW-1-t]);
         chk("R10 ws", word_sel, 1'b0);
      end
      for (int t = 0; t < 5; t++) begin
         tick();
         chk("R11 stall ws", word_sel, 1'b0);
         chk("R11 stall sck", sck_en, 1'b0);
         chk("R11 stall data", ser_data, 1'b0);
         chk("R11 stall uf", underflow, 1'b0);
      end
      feed(1, 1);
      tick();
      chk("R11 resume ws", word_sel, 1'b1);
      chk("R11 resume sck", sck_en, 1'b1);
      chk("R11 resume msb", ser_data, samp[1][SW-1]);
      tick();
      chk("R11 resume bit2", ser_data, samp[1][SW-2]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got hung expected done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) samp[i] = 16'hB4E1 ^ SW'(i * 16'h2F39);
      t_reset();
      run_stream("R3 R2 one-bit lag", 1'b0, 1'b0, 1'b0, 1'b1, 1);
      run_stream("R4 R2 zero lag", 1'b1, 1'b0, 1'b0, 1'b0, 0);
      run_stream("R5 compress forces zero lag", 1'b0, 1'b1, 1'b0, 1'b1, 0);
      run_stream("R6 mute", 1'b1, 1'b0, 1'b1, 1'b1, 0);
      t_handshake();
      t_underflow();
      t_burst_ignored();
      t_burst();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule